// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks the frame to evict from a fixed pool of physical frames using the second-chance (clock) policy. Four flags are kept for every frame: resident, referenced, dirty and locked. An access to a frame is reported on the reference input, which sets that frame's referenced flag. A separate update port loads the resident, dirty and locked flags of one frame at a time, for example after a page has been brought in or pinned for I/O.

When the victim request is accepted, a single hand walks the frames in circular order and looks at one frame per clock cycle. A locked frame is always passed over. A frame that is not resident is taken at once. A resident frame that has its referenced flag set loses that flag and is passed over. A resident frame whose referenced flag is already clear is taken. The result pulse gives the chosen index and says whether the frame must be written back first. If the hand makes two full turns without finding a candidate, the pulse reports that no victim exists. Moving page data and rewriting the page table are the job of the surrounding logic.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset the hand is at frame 0 and all flags of all frames are clear. `req_ready` is 1 and `vic_done` is 0, so the first request selects frame 0 with `vic_writeback` = 0 after one examined frame.
- R2: A one-cycle pulse on `ref_valid` sets the referenced flag of frame `ref_idx`. The update port leaves that flag unchanged.
- R3: During a sweep, a resident, unlocked frame with its referenced flag set has that flag cleared and is passed over. The first resident, unlocked frame found with the flag clear is selected. A frame that every resident frame can pass over once is therefore taken on the hand's second visit.
- R4: A frame whose locked flag is 1 is never selected, whether or not it is resident.
- R5: An unlocked frame whose resident flag is 0 is selected as soon as the hand reaches it, even if its referenced flag is set.
- R6: `vic_writeback` is 1 exactly when the selected frame was resident and dirty at the time it was examined. An invalid dirty frame reports 0.
- R7: The hand moves one frame per examined cycle, wraps from frame FRAMES-1 to frame 0, and rests one position beyond the selected frame. It does not move between sweeps.
- R8: If no frame is selected within 2*FRAMES examined cycles, `vic_done` pulses with `vic_none` = 1. The hand is then back where the sweep started.
- R9: `req_ready` is 1 only while no sweep is running, and a request is accepted on a cycle where `req_valid` and `req_ready` are both 1. The first frame is examined on the next edge. `vic_done` is a one-cycle pulse that rises on the edge after the deciding frame is examined, so a sweep that examines k frames raises `vic_done` k edges after acceptance.
- R10: If a reference to a frame arrives on the same cycle that the sweep clears that frame's referenced flag, the flag stays set.
- R11: A one-cycle pulse on `upd_valid` loads the resident, dirty and locked flags of frame `upd_idx` from `upd_resident`, `upd_dirty` and `upd_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Access report; sets the referenced flag |
| ref_idx | input | IDX_W | Frame accessed |
| upd_valid | input | 1 | Load the resident, dirty and locked flags of one frame |
| upd_idx | input | IDX_W | Frame to update |
| upd_resident | input | 1 | New resident flag |
| upd_dirty | input | 1 | New dirty flag |
| upd_lock | input | 1 | New locked flag |
| req_valid | input | 1 | Victim request |
| req_ready | output | 1 | Selector is idle and can accept a request |
| vic_done | output | 1 | One-cycle completion pulse |
| vic_idx | output | IDX_W | Selected frame |
| vic_writeback | output | 1 | Selected frame must be written back first |
| vic_none | output | 1 | No frame could be selected |

## Verification
The hardest case to reach from the ports is a reference that lands on the very cycle the hand clears the same frame's flag. No status output shows when the hand examines a frame. The bench gets there by counting edges: after acceptance, the first examined frame is the one where the hand rests. The bench pulses a reference to that frame on exactly that cycle, with every frame referenced, and then checks that the frame survives a second visit, so the frame after it is selected on the eighteenth examined cycle. The all-locked case is reached by locking every frame. It is then confirmed both by the error pulse and by its latency of exactly two turns.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

  typedef struct packed {
    logic resident;
    logic refd;
    logic dirty;
    logic lock;
  } frame_flags_t;

  typedef enum logic [1:0] {
    EXAM_SKIP  = 2'd0,
    EXAM_CLEAR = 2'd1,
    EXAM_PICK  = 2'd2
  } exam_e;

  // Verdict for the frame under the hand.
  function automatic exam_e classify(frame_flags_t f);
    if (f.lock)      return EXAM_SKIP;
    if (!f.resident) return EXAM_PICK;
    if (f.refd)      return EXAM_CLEAR;
    return EXAM_PICK;
  endfunction

  // Write-back is needed only for a resident, modified page.
  function automatic logic needs_writeback(frame_flags_t f);
    return f.resident & f.dirty;
  endfunction

endpackage

// File: rtl/cvs_frame_table.sv
module cvs_frame_table
  import cvs_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_resident,
  input  logic              upd_dirty,
  input  logic              upd_lock,
  input  logic              ref_en,
  input  logic [IDX_W-1:0]  ref_idx,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output frame_flags_t      rd_flags,
  output logic [FRAMES-1:0] resident_vec,
  output logic [FRAMES-1:0] dirty_vec,
  output logic [FRAMES-1:0] lock_vec
);

  logic [FRAMES-1:0] res_q, ref_q, dirty_q, lock_q;
  logic [FRAMES-1:0] res_d, ref_d, dirty_d, lock_d;

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    localparam logic [IDX_W-1:0] SELF = IDX_W'(g);
    logic hit_upd, hit_ref, hit_clr;
    assign hit_upd = upd_en && (upd_idx == SELF);
    assign hit_ref = ref_en && (ref_idx == SELF);
    assign hit_clr = clr_en && (clr_idx == SELF);
    assign res_d[g]   = hit_upd ? upd_resident : res_q[g];
    assign dirty_d[g] = hit_upd ? upd_dirty    : dirty_q[g];
    assign lock_d[g]  = hit_upd ? upd_lock     : lock_q[g];
    // a fresh reference outranks the sweep's clear
    assign ref_d[g]   = hit_ref ? 1'b1 : (hit_clr ? 1'b0 : ref_q[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      lock_q  <= '0;
    end else begin
      res_q   <= res_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
      lock_q  <= lock_d;
    end
  end

  always_comb begin
    rd_flags.resident = res_q[rd_idx];
    rd_flags.refd     = ref_q[rd_idx];
    rd_flags.dirty    = dirty_q[rd_idx];
    rd_flags.lock     = lock_q[rd_idx];
  end

  assign resident_vec = res_q;
  assign dirty_vec    = dirty_q;
  assign lock_vec     = lock_q;

  // R10: a reference always leaves its frame marked, even against a clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en |=> ref_q[$past(ref_idx)]);

endmodule

// File: rtl/cvs_hand.sv
module cvs_hand #(
  parameter int FRAMES = 16,
  parameter int IDX_W  = $clog2(FRAMES),
  parameter int CNT_W  = $clog2(2 * FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             cnt_clr,
  output logic [IDX_W-1:0] hand,
  output logic [CNT_W-1:0] steps
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  function automatic logic [IDX_W-1:0] wrap_inc(logic [IDX_W-1:0] h);
    return (h == LAST) ? '0 : h + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hand  <= '0;
      steps <= '0;
    end else begin
      if (adv) hand <= wrap_inc(hand);
      if (cnt_clr)  steps <= '0;
      else if (adv) steps <= steps + 1'b1;
    end
  end

  // R7: the hand rests whenever no frame is being examined
  assert_hand_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(hand));

endmodule

// File: rtl/cvs_sweep_ctrl.sv
module cvs_sweep_ctrl
  import cvs_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int IDX_W  = $clog2(FRAMES),
  parameter int CNT_W  = $clog2(2 * FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  frame_flags_t     cur,
  input  logic [IDX_W-1:0] hand,
  input  logic [CNT_W-1:0] steps,
  output logic             adv,
  output logic             cnt_clr,
  output logic             clr_en,
  output logic             done,
  output logic [IDX_W-1:0] victim,
  output logic             writeback,
  output logic             none
);

  localparam logic [CNT_W-1:0] STEP_LIMIT = CNT_W'(2 * FRAMES - 1);

  typedef enum logic {ST_IDLE, ST_SCAN} st_e;
  st_e   st_q;
  exam_e verdict;
  logic  accept, scanning, pick, give_up;

  always_comb verdict = classify(cur);

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign scanning  = (st_q == ST_SCAN);
  assign pick      = scanning && (verdict == EXAM_PICK);
  assign give_up   = scanning && !pick && (steps == STEP_LIMIT);
  assign adv       = scanning;
  assign cnt_clr   = accept;
  assign clr_en    = scanning && (verdict == EXAM_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      done      <= 1'b0;
      victim    <= '0;
      writeback <= 1'b0;
      none      <= 1'b0;
    end else begin
      done <= pick || give_up;
      if (pick || give_up) begin
        victim    <= hand;
        writeback <= pick && needs_writeback(cur);
        none      <= give_up;
      end
      case (st_q)
        ST_IDLE: if (accept) st_q <= ST_SCAN;
        ST_SCAN: if (pick || give_up) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: an accepted request makes the selector busy on the next cycle
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R9: completion lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
  import cvs_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_resident,
  input  logic             upd_dirty,
  input  logic             upd_lock,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             vic_done,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_writeback,
  output logic             vic_none
);

  localparam int CNT_W = $clog2(2 * FRAMES);

  frame_flags_t      cur_flags;
  logic [IDX_W-1:0]  hand;
  logic [CNT_W-1:0]  steps;
  logic              adv, cnt_clr, clr_en;
  logic [FRAMES-1:0] resident_vec, dirty_vec, lock_vec;

  cvs_frame_table #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_en       (upd_valid),
    .upd_idx      (upd_idx),
    .upd_resident (upd_resident),
    .upd_dirty    (upd_dirty),
    .upd_lock     (upd_lock),
    .ref_en       (ref_valid),
    .ref_idx      (ref_idx),
    .clr_en       (clr_en),
    .clr_idx      (hand),
    .rd_idx       (hand),
    .rd_flags     (cur_flags),
    .resident_vec (resident_vec),
    .dirty_vec    (dirty_vec),
    .lock_vec     (lock_vec)
  );

  cvs_hand #(.FRAMES(FRAMES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_hand (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .cnt_clr (cnt_clr),
    .hand    (hand),
    .steps   (steps)
  );

  cvs_sweep_ctrl #(.FRAMES(FRAMES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cur       (cur_flags),
    .hand      (hand),
    .steps     (steps),
    .adv       (adv),
    .cnt_clr   (cnt_clr),
    .clr_en    (clr_en),
    .done      (vic_done),
    .victim    (vic_idx),
    .writeback (vic_writeback),
    .none      (vic_none)
  );

  // R4: the reported frame was not pinned when it was examined
  assert_no_locked_victim_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_done && !vic_none) |-> ((($past(lock_vec) >> vic_idx) & FRAMES'(1)) == '0));

  // R6: write-back flag follows the examined resident and dirty state
  assert_writeback_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_done && !vic_none) |->
      (vic_writeback == (((($past(resident_vec & dirty_vec)) >> vic_idx) & FRAMES'(1)) != '0)));

endmodule

// File: tb/clock_victim_sel_bench.sv
`timescale 1ns/1ps
module clock_victim_sel_bench;

  localparam int NF = 16;
  localparam int IW = $clog2(NF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_valid = 1'b0;
  logic [IW-1:0] ref_idx = '0;
  logic          upd_valid = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic          upd_resident = 1'b0, upd_dirty = 1'b0, upd_lock = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready, vic_done, vic_writeback, vic_none;
  logic [IW-1:0] vic_idx;

  always #10 clk = ~clk;

  clock_victim_sel #(.FRAMES(NF)) u_clock_victim_sel (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_idx(ref_idx),
    .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_resident(upd_resident), .upd_dirty(upd_dirty), .upd_lock(upd_lock),
    .req_valid(req_valid), .req_ready(req_ready),
    .vic_done(vic_done), .vic_idx(vic_idx),
    .vic_writeback(vic_writeback), .vic_none(vic_none)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct { int idx; bit wb; bit none; string tag; } exp_t;
  exp_t sb[$];

  bit m_res[NF], m_ref[NF], m_dirty[NF], m_lock[NF];
  int m_hand = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Monitor: compare each completion against the scoreboard
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (vic_done) begin
        if (sb.size() == 0) check(0, "R9", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(vic_none == e.none, (e.none ? "R8" : e.tag), "none flag", int'(vic_none), int'(e.none));
          if (!e.none) begin
            check(int'(vic_idx) == e.idx, e.tag, "victim index", int'(vic_idx), e.idx);
            check(vic_writeback == e.wb, "R6", "writeback flag", int'(vic_writeback), int'(e.wb));
          end
        end
        if (prev_done) check(0, "R9", "done longer than one cycle", 2, 1);
      end
      prev_done = vic_done;
    end
  end

  // Independent model of one sweep
  task automatic model_sweep(input bit hit, output int vid, output bit wb,
                             output bit none, output int steps);
    int h;
    bit found;
    h = m_hand; found = 0; vid = 0; wb = 0; steps = 0;
    for (int s = 0; s < 2 * NF && !found; s++) begin
      steps = s + 1;
      if (!m_lock[h]) begin
        if (!m_res[h] || !m_ref[h]) begin
          found = 1; vid = h; wb = m_res[h] && m_dirty[h];
        end else if (!(hit && s == 0)) m_ref[h] = 0;
      end
      h = (h + 1) % NF;
    end
    if (hit && (steps == 1 || m_lock[m_hand])) m_ref[m_hand] = 1;
    none = !found;
    m_hand = h;
  endtask

  task automatic upd(int idx, bit r, bit d, bit l);
    upd_valid = 1; upd_idx = IW'(idx); upd_resident = r; upd_dirty = d; upd_lock = l;
    @(negedge clk);
    upd_valid = 0;
    m_res[idx] = r; m_dirty[idx] = d; m_lock[idx] = l;
  endtask

  task automatic touch(int idx);
    ref_valid = 1; ref_idx = IW'(idx);
    @(negedge clk);
    ref_valid = 0;
    m_ref[idx] = 1;
  endtask

  // Driver: push the expected result, then run one request
  task automatic request(bit hit, string tag);
    int vid, steps, cnt, start;
    bit wb, none;
    exp_t e;
    start = m_hand;
    model_sweep(hit, vid, wb, none, steps);
    e.idx = vid; e.wb = wb; e.none = none; e.tag = tag;
    sb.push_back(e);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    cnt = 1;
    check(req_ready == 0, "R9", "ready while busy", int'(req_ready), 0);
    if (hit) begin ref_valid = 1; ref_idx = IW'(start); end
    while (!vic_done && cnt < 200) begin
      @(negedge clk);
      ref_valid = 0;
      cnt++;
    end
    ref_valid = 0;
    check(cnt == steps + 1, tag, "completion latency", cnt, steps + 1);
    @(negedge clk);
    check(req_ready == 1, "R9", "ready after done", int'(req_ready), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NF; i++) begin
      m_res[i] = 0; m_ref[i] = 0; m_dirty[i] = 0; m_lock[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle state after reset
    check(req_ready == 1, "R1", "ready after reset", int'(req_ready), 1);
    check(vic_done == 0, "R1", "done after reset", int'(vic_done), 0);
    // R1/R5: empty pool gives frame 0 at once
    request(0, "R1");

    // R11: load every frame resident and clean
    for (int i = 0; i < NF; i++) upd(i, 1, 0, 0);
    // R2/R3: referenced frames are passed over and cleared
    touch(1); touch(2); touch(3);
    request(0, "R3");

    // R6: dirty victim needs write-back
    upd(5, 1, 1, 0);
    request(0, "R6");

    // R4: locked frames are skipped
    upd(6, 1, 0, 1); upd(7, 1, 1, 1);
    request(0, "R4");

    // R7: wrap from last frame to frame 0
    for (int i = 9; i < NF; i++) touch(i);
    request(0, "R7");

    // R5: invalid frame taken despite reference; R6 invalid dirty -> no write-back
    touch(1); touch(2); touch(3);
    upd(3, 0, 1, 0);
    request(0, "R5");
    upd(3, 1, 0, 0);
    upd(6, 1, 0, 0); upd(7, 1, 0, 0);

    // R3: all referenced -> second visit to the start frame
    for (int i = 0; i < NF; i++) touch(i);
    request(0, "R3");

    // R10: reference on the clearing cycle keeps the start frame alive
    for (int i = 0; i < NF; i++) touch(i);
    request(1, "R10");

    // R8: every frame pinned -> no victim after two turns
    for (int i = 0; i < NF; i++) upd(i, 1, 0, 1);
    request(0, "R8");
    // R4/R8: one frame released becomes the only choice
    upd(10, 1, 1, 0);
    request(0, "R4");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R9", "pending results", sb.size(), 0);
    finish_run();
  end

endmodule